// File: doc/BRIEF.md
# Register Reservation Scoreboard

This block decides whether the instruction at the head of an in-order issue queue may leave for execution. It keeps one reservation flag per architectural register, meaning a write to that register is still outstanding. The issue stage presents the head instruction's two source indices, its destination index and whether it writes a destination. The block answers with a combinational issue permission.

When the instruction is valid and permitted, it issues on the next rising clock edge, and the block reserves its destination. Writeback from the functional units arrives on two completion ports, and each one releases the reservation of the register it names. The head instruction is the only candidate. If it is refused, every younger instruction waits behind it, so the order of issue is always the program order.

A completion seen in the same cycle counts as already released when issue permission is judged. Register zero is hardwired and can never be reserved.

Top module: `issue_scoreboard`

## Requirements
- R1: After synchronous reset, no register is reserved, so any candidate is permitted.
- R2: A valid, permitted candidate that writes destination d (d nonzero) leaves d reserved from the following cycle on.
- R3: Issue permission is low while either source index names a reserved register that no completion port releases in that cycle.
- R4: Issue permission is low while the destination names a reserved register that no completion port releases in that cycle, when the candidate writes a destination.
- R5: A valid completion naming register r leaves r unreserved from the following cycle, unless a new issue reserves r in the same cycle.
- R6: A completion releasing a blocking register in the same cycle lets issue permission be high in that cycle.
- R7: Both completion ports can release two different registers in the same cycle.
- R8: A release and a new reservation of the same register in one cycle leave that register reserved.
- R9: Register 0 is never reserved; a candidate writing register 0 never blocks a later candidate.
- R10: A refused or invalid candidate reserves nothing.
- R11: A candidate whose destination-write flag is low reserves nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_valid | input | 1 | Head of the issue queue holds an instruction |
| cand_src_a | input | 5 | First source register index |
| cand_src_b | input | 5 | Second source register index |
| cand_dst | input | 5 | Destination register index |
| cand_has_dst | input | 1 | Candidate writes its destination |
| cmp_valid | input | 2 | Completion port valid, one bit per port |
| cmp_idx | input | 10 | Completion register indices, port p in bits [5p+4:5p] |
| issue_ok | output | 1 | Candidate may issue in this cycle |

## Verification
Issue permission is combinational, so it is due in the same cycle as the candidate and completion inputs. The bench drives inputs just after a falling edge and samples one time step later, before the next rising edge. Reservations and releases take effect at the next rising edge. The bench reads them back in the following cycle by presenting a probe candidate that uses the register as a source, with no completion active, and checking the permission it receives.

// File: rtl/issue_sb_pkg.sv
package issue_sb_pkg;
    parameter int REG_COUNT = 32;
    parameter int CMP_PORTS = 2;
    localparam int IDX_W = $clog2(REG_COUNT);

    typedef logic [IDX_W-1:0]     reg_idx_t;
    typedef logic [REG_COUNT-1:0] reg_mask_t;

    typedef struct packed {
        logic     valid;
        reg_idx_t src_a;
        reg_idx_t src_b;
        reg_idx_t dst;
        logic     has_dst;
    } cand_t;

    typedef struct packed {
        logic     valid;
        reg_idx_t idx;
    } cmp_t;

    // One-hot mask for a register index; register zero never appears.
    function automatic reg_mask_t idx_to_mask(input reg_idx_t idx, input logic en);
        reg_mask_t m;
        m = '0;
        if (en && idx != '0) m[idx] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/sb_release_mask.sv
module sb_release_mask
    import issue_sb_pkg::*;
(
    input  cmp_t      cmp [CMP_PORTS],
    output reg_mask_t rel_mask
);
    reg_mask_t per_port [CMP_PORTS];

    for (genvar p = 0; p < CMP_PORTS; p++) begin : g_port
        assign per_port[p] = idx_to_mask(cmp[p].idx, cmp[p].valid);
    end

    always_comb begin
        rel_mask = '0;
        for (int p = 0; p < CMP_PORTS; p++) rel_mask = rel_mask | per_port[p];
    end
endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check
    import issue_sb_pkg::*;
(
    input  cand_t     cand,
    input  reg_mask_t resv,
    input  reg_mask_t rel_mask,
    output logic      permit
);
    reg_mask_t live;
    logic      blk_a, blk_b, blk_d;

    always_comb begin
        live  = resv & ~rel_mask;
        blk_a = live[cand.src_a];
        blk_b = live[cand.src_b];
        blk_d = cand.has_dst & live[cand.dst];
        permit = ~(blk_a | blk_b | blk_d);
    end
endmodule

// File: rtl/sb_resv_bank.sv
module sb_resv_bank
    import issue_sb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  reg_mask_t set_mask,
    input  reg_mask_t clr_mask,
    output reg_mask_t resv
);
    reg_mask_t resv_q;

    for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)              resv_q[r] <= 1'b0;
            else if (set_mask[r]) resv_q[r] <= 1'b1;
            else if (clr_mask[r]) resv_q[r] <= 1'b0;
        end

        // R2
        set_holds_chk: assert property (@(posedge clk) disable iff (rst)
            set_mask[r] |=> resv_q[r]);
        // R5
        clr_holds_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_mask[r] && !set_mask[r]) |=> !resv_q[r]);
    end

    assign resv = resv_q;

    // R9
    zero_free_chk: assert property (@(posedge clk) disable iff (rst) !resv_q[0]);
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
    import issue_sb_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cand_valid,
    input  logic [IDX_W-1:0]           cand_src_a,
    input  logic [IDX_W-1:0]           cand_src_b,
    input  logic [IDX_W-1:0]           cand_dst,
    input  logic                       cand_has_dst,
    input  logic [CMP_PORTS-1:0]       cmp_valid,
    input  logic [CMP_PORTS*IDX_W-1:0] cmp_idx,
    output logic                       issue_ok
);
    cand_t     cand;
    cmp_t      cmp [CMP_PORTS];
    reg_mask_t rel_mask, set_mask, resv;
    logic      fire;

    assign cand = '{valid: cand_valid, src_a: cand_src_a, src_b: cand_src_b,
                    dst: cand_dst, has_dst: cand_has_dst};

    for (genvar p = 0; p < CMP_PORTS; p++) begin : g_cmp
        assign cmp[p].valid = cmp_valid[p];
        assign cmp[p].idx   = cmp_idx[p*IDX_W +: IDX_W];
    end

    sb_release_mask u_rel (.cmp(cmp), .rel_mask(rel_mask));

    sb_hazard_check u_haz (.cand(cand), .resv(resv), .rel_mask(rel_mask),
                           .permit(issue_ok));

    assign fire     = cand.valid & issue_ok;
    assign set_mask = idx_to_mask(cand.dst, fire & cand.has_dst);

    sb_resv_bank u_bank (.clk(clk), .rst(rst), .set_mask(set_mask),
                         .clr_mask(rel_mask), .resv(resv));

    // R10
    blocked_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        !fire |-> set_mask == '0);
    // R11
    nodst_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        !cand.has_dst |-> set_mask == '0);
    // R3
    src_block_chk: assert property (@(posedge clk) disable iff (rst)
        (resv[cand.src_a] && !rel_mask[cand.src_a]) |-> !issue_ok);
endmodule

// File: tb/issue_scoreboard_tb_top.sv
module issue_scoreboard_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cand_valid = 1'b0;
    logic [4:0] cand_src_a = '0, cand_src_b = '0, cand_dst = '0;
    logic       cand_has_dst = 1'b0;
    logic [1:0] cmp_valid = '0;
    logic [9:0] cmp_idx = '0;
    logic       issue_ok;
    int         total = 0, bad = 0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    issue_scoreboard dut_i (.clk(clk), .rst(rst), .cand_valid(cand_valid),
        .cand_src_a(cand_src_a), .cand_src_b(cand_src_b), .cand_dst(cand_dst),
        .cand_has_dst(cand_has_dst), .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
        .issue_ok(issue_ok));

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: issue_ok=%0b expected %0b", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs after a falling edge and return the permission.
    task automatic step(input logic v, input logic [4:0] a, input logic [4:0] b,
                        input logic [4:0] d, input logic hd,
                        input logic c0v, input logic [4:0] c0,
                        input logic c1v, input logic [4:0] c1,
                        output logic ok);
        @(negedge clk);
        cand_valid = v; cand_src_a = a; cand_src_b = b;
        cand_dst = d; cand_has_dst = hd;
        cmp_valid = {c1v, c0v}; cmp_idx = {c1, c0};
        #1 ok = issue_ok;
    endtask

    // Permission of an invalid candidate reading r: high means r is free.
    task automatic probe(input logic [4:0] r, output logic ok);
        step(1'b0, r, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, ok);
    endtask

    task automatic issue_dst(input logic [4:0] d);
        logic ok;
        step(1'b1, 5'd0, 5'd0, d, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, ok);
        check("R2 issue", ok, 1'b1);
    endtask

    task automatic complete(input logic [4:0] r);
        logic ok;
        step(1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b1, r, 1'b0, 5'd0, ok);
    endtask

    task automatic t_reset;
        logic ok;
        probe(5'd5, ok);  check("R1", ok, 1'b1);
        probe(5'd31, ok); check("R1", ok, 1'b1);
    endtask

    task automatic t_set_and_block;
        logic ok;
        issue_dst(5'd5);
        probe(5'd5, ok); check("R2", ok, 1'b0);
        step(1'b1, 5'd5, 5'd1, 5'd7, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, ok);
        check("R3 src_a", ok, 1'b0);
        step(1'b1, 5'd2, 5'd5, 5'd7, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, ok);
        check("R3 src_b", ok, 1'b0);
        probe(5'd7, ok); check("R10", ok, 1'b1);
        step(1'b1, 5'd1, 5'd2, 5'd5, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, ok);
        check("R4", ok, 1'b0);
        complete(5'd5);
        probe(5'd5, ok); check("R5", ok, 1'b1);
    endtask

    task automatic t_bypass;
        logic ok;
        issue_dst(5'd9);
        step(1'b1, 5'd9, 5'd0, 5'd10, 1'b1, 1'b0, 5'd0, 1'b1, 5'd9, ok);
        check("R6", ok, 1'b1);
        probe(5'd10, ok); check("R6 dst set", ok, 1'b0);
        probe(5'd9, ok);  check("R5", ok, 1'b1);
        complete(5'd10);
    endtask

    task automatic t_dual;
        logic ok;
        issue_dst(5'd11);
        issue_dst(5'd12);
        step(1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b1, 5'd11, 1'b1, 5'd12, ok);
        probe(5'd11, ok); check("R7 port0", ok, 1'b1);
        probe(5'd12, ok); check("R7 port1", ok, 1'b1);
    endtask

    task automatic t_clr_set;
        logic ok;
        issue_dst(5'd13);
        step(1'b1, 5'd0, 5'd0, 5'd13, 1'b1, 1'b1, 5'd13, 1'b0, 5'd0, ok);
        check("R8 permit", ok, 1'b1);
        probe(5'd13, ok); check("R8", ok, 1'b0);
        complete(5'd13);
    endtask

    task automatic t_zero_nodst;
        logic ok;
        issue_dst(5'd0);
        step(1'b1, 5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, ok);
        check("R9", ok, 1'b1);
        step(1'b1, 5'd0, 5'd0, 5'd14, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, ok);
        check("R11 issue", ok, 1'b1);
        probe(5'd14, ok); check("R11", ok, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_set_and_block();
        t_bypass();
        t_dual();
        t_clr_set();
        t_zero_nodst();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule